// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Interrupt Controller

This block holds a three-field time-of-day alarm (minute, hour, day of week) and checks it once per minute against the value the clock is about to roll into. Each alarm field carries a mask bit in its top position. Setting the masks from the day field downward widens the alarm from a weekly match to a daily, hourly or once-per-minute event. A match sets a time-of-day flag. A watchdog request arrives from outside and sets a watchdog flag.

The two flags drive two open-drain interrupt pins, A and B. A command byte chooses which event drives which pin, masks either event away from its pin, and selects the signalling mode. In level mode a flag holds its pin active until software clears it. In pulse mode the pin is active for a bounded number of millisecond ticks and then releases. The clock counters and the watchdog countdown sit outside this block. It receives the clock's next minute, hour and day, the current seconds, a strobe marking the start of the last hundredth of each second, and watchdog set and clear strobes.

Top module: `tod_irq_ctrl`

## Requirements
- R1: Addresses 3, 5 and 7 hold the minute, hour and day alarm bytes. Bit 7 of each is its mask. A read returns on `bus_rdata` in the cycle after the access. Addresses 3 and 5 return the full written byte. Address 7 returns bit 7 and bits 2:0, with bits 6:3 always 0.
- R2: The check runs in a cycle with `tick_h99`=1 and `cur_sec`=8'h59. With all masks clear, the time-of-day flag sets only if `nxt_min`, `nxt_hr` (bits 6:0, including the 12/24 and PM bits) and `nxt_day` all equal their alarm fields.
- R3: If only the day mask is set, the day is ignored. Hour and minute must match.
- R4: If the day and hour masks are set, only the minute must match.
- R5: If all three masks are set, every check sets the flag, once per minute.
- R6: The flag never sets without a check strobe. A strobe with `cur_sec` other than 8'h59 sets nothing.
- R7: Any read or write of address 3, 5 or 7 clears the time-of-day flag. If an alarm hit falls in the same cycle, the hit wins and the flag is set.
- R8: `wd_evt` sets the watchdog flag. `wd_clr` clears it, and `wd_evt` wins if both arrive together.
- R9: Address 11 is the command byte. It holds bit 6 swap, bit 4 pulse mode, bit 3 watchdog mask, bit 2 time-of-day mask, bit 1 watchdog flag and bit 0 time-of-day flag, and reads 0 in bits 7 and 5. Writes change only bits 6, 4, 3 and 2. The flags are read-only.
- R10: With swap=1, pin A carries the time-of-day request and pin B the watchdog request. With swap=0 the routing is reversed. Each pin changes one cycle after its flag.
- R11: A mask bit of 1 keeps its event off its pin but leaves the flag readable.
- R12: In pulse mode an event restarts a tick count. The flag and its pin stay active until the (PULSE_TICKS+1)-th `ms_tick` after the event, and both release in that cycle.
- R13: After reset, all alarm bytes, command bits and flags are 0 and both pins are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| tick_h99 | input | 1 | One-cycle strobe as hundredths enter 99 |
| cur_sec | input | 8 | Current BCD seconds |
| nxt_min | input | 7 | BCD minutes after the coming rollover |
| nxt_hr | input | 7 | Hours after the coming rollover, clock format |
| nxt_day | input | 3 | Day of week after the coming rollover |
| wd_evt | input | 1 | Watchdog expiry strobe |
| wd_clr | input | 1 | Watchdog register access strobe |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| int_a_oe | output | 1 | Pin A pull-down enable (1 = pin driven low) |
| int_b_oe | output | 1 | Pin B pull-down enable (1 = pin driven low) |

## Verification
The hardest state to reach from the ports is a clearing register access that falls in the same cycle as an alarm hit. The bench arranges it by raising `bus_en` on address 3 in the same cycle as the check strobe, with all masks set so the hit is certain. It also runs a pulse-mode event through exactly PULSE_TICKS ticks and then one more. It reads the command byte at both points to show the flag holding and then releasing. A behavioural model predicts the read data and both pins on every cycle.

// File: rtl/tod_irq_pkg.sv
package tod_irq_pkg;
  // command byte bit positions (software-visible layout)
  localparam int CMD_TODF  = 0;
  localparam int CMD_WDF   = 1;
  localparam int CMD_TODM  = 2;
  localparam int CMD_WDM   = 3;
  localparam int CMD_PULSE = 4;
  localparam int CMD_SWAP  = 6;

  localparam int NUM_CH = 2;
  localparam int CH_TOD = 0;
  localparam int CH_WD  = 1;

  typedef struct packed {
    logic swap;
    logic pulse;
    logic wd_mask;
    logic tod_mask;
  } irq_cfg_t;
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_min,
  input  logic          wr_hr,
  input  logic          wr_day,
  input  logic [DW-1:0] wdata,
  input  logic          chk_stb,
  input  logic [DW-2:0] nxt_min,
  input  logic [DW-2:0] nxt_hr,
  input  logic [2:0]    nxt_day,
  output logic [DW-1:0] alm_min,
  output logic [DW-1:0] alm_hr,
  output logic [DW-1:0] alm_day,
  output logic          hit
);
  localparam int MB = DW - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_min <= '0;
      alm_hr  <= '0;
      alm_day <= '0;
    end else begin
      if (wr_min) alm_min <= wdata;
      if (wr_hr)  alm_hr  <= wdata;
      if (wr_day) alm_day <= {wdata[MB], {(DW-4){1'b0}}, wdata[2:0]};
    end
  end

  logic min_ok, hr_ok, day_ok;
  always_comb begin
    min_ok = alm_min[MB] | (alm_min[MB-1:0] == nxt_min);
    hr_ok  = alm_hr[MB]  | (alm_hr[MB-1:0]  == nxt_hr);
    day_ok = alm_day[MB] | (alm_day[2:0]    == nxt_day);
    hit    = chk_stb & min_ok & hr_ok & day_ok;
  end
endmodule

// File: rtl/irq_flag_ch.sv
module irq_flag_ch #(
  parameter int PULSE_TICKS = 3,
  localparam int CNT_W = $clog2(PULSE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic pulse_mode,
  input  logic ms_tick,
  output logic flag_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      cnt_q  <= '0;
    end else if (set_i) begin
      flag_o <= 1'b1;
      cnt_q  <= '0;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end else if (pulse_mode && flag_o && ms_tick) begin
      if (cnt_q == CNT_W'(PULSE_TICKS)) flag_o <= 1'b0;
      else                              cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import tod_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_cfg_t cfg,
  input  logic     tod_flag,
  input  logic     wd_flag,
  output logic     int_a_oe,
  output logic     int_b_oe
);
  logic tod_req, wd_req;
  always_comb begin
    tod_req = tod_flag & ~cfg.tod_mask;
    wd_req  = wd_flag  & ~cfg.wd_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_a_oe <= 1'b0;
      int_b_oe <= 1'b0;
    end else begin
      int_a_oe <= cfg.swap ? tod_req : wd_req;
      int_b_oe <= cfg.swap ? wd_req  : tod_req;
    end
  end
endmodule

// File: rtl/tod_irq_ctrl.sv
module tod_irq_ctrl
  import tod_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int PULSE_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick_h99,
  input  logic [7:0]        cur_sec,
  input  logic [6:0]        nxt_min,
  input  logic [6:0]        nxt_hr,
  input  logic [2:0]        nxt_day,
  input  logic              wd_evt,
  input  logic              wd_clr,
  input  logic              ms_tick,
  output logic              int_a_oe,
  output logic              int_b_oe
);
  localparam logic [ADDR_W-1:0] A_MIN = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_HR  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_DAY = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(11);

  logic sel_min, sel_hr, sel_day, sel_cmd, alm_acc, chk_stb, tod_hit;
  always_comb begin
    sel_min = bus_addr == A_MIN;
    sel_hr  = bus_addr == A_HR;
    sel_day = bus_addr == A_DAY;
    sel_cmd = bus_addr == A_CMD;
    alm_acc = bus_en & (sel_min | sel_hr | sel_day);
    chk_stb = tick_h99 & (cur_sec == 8'h59);
  end

  logic [7:0] alm_min, alm_hr, alm_day;
  tod_alarm_regs #(.DW(8)) u_alarm (
    .clk(clk), .rst(rst),
    .wr_min(bus_en & bus_we & sel_min),
    .wr_hr (bus_en & bus_we & sel_hr),
    .wr_day(bus_en & bus_we & sel_day),
    .wdata(bus_wdata), .chk_stb(chk_stb),
    .nxt_min(nxt_min), .nxt_hr(nxt_hr), .nxt_day(nxt_day),
    .alm_min(alm_min), .alm_hr(alm_hr), .alm_day(alm_day),
    .hit(tod_hit)
  );

  irq_cfg_t cfg_q;
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (bus_en && bus_we && sel_cmd)
      cfg_q <= '{swap:     bus_wdata[CMD_SWAP],
                 pulse:    bus_wdata[CMD_PULSE],
                 wd_mask:  bus_wdata[CMD_WDM],
                 tod_mask: bus_wdata[CMD_TODM]};
  end

  logic [NUM_CH-1:0] ch_set, ch_clr, ch_flag;
  always_comb begin
    ch_set[CH_TOD] = tod_hit;
    ch_clr[CH_TOD] = alm_acc;
    ch_set[CH_WD]  = wd_evt;
    ch_clr[CH_WD]  = wd_clr;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    irq_flag_ch #(.PULSE_TICKS(PULSE_TICKS)) u_flag (
      .clk(clk), .rst(rst),
      .set_i(ch_set[g]), .clr_i(ch_clr[g]),
      .pulse_mode(cfg_q.pulse), .ms_tick(ms_tick),
      .flag_o(ch_flag[g])
    );
  end

  logic tod_flag, wd_flag;
  always_comb begin
    tod_flag = ch_flag[CH_TOD];
    wd_flag  = ch_flag[CH_WD];
  end

  irq_router u_route (
    .clk(clk), .rst(rst), .cfg(cfg_q),
    .tod_flag(tod_flag), .wd_flag(wd_flag),
    .int_a_oe(int_a_oe), .int_b_oe(int_b_oe)
  );

  logic [7:0] cmd_rd;
  always_comb begin
    cmd_rd = '0;
    cmd_rd[CMD_SWAP]  = cfg_q.swap;
    cmd_rd[CMD_PULSE] = cfg_q.pulse;
    cmd_rd[CMD_WDM]   = cfg_q.wd_mask;
    cmd_rd[CMD_TODM]  = cfg_q.tod_mask;
    cmd_rd[CMD_WDF]   = wd_flag;
    cmd_rd[CMD_TODF]  = tod_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_en && !bus_we) begin
      unique case (1'b1)
        sel_min: bus_rdata <= alm_min;
        sel_hr:  bus_rdata <= alm_hr;
        sel_day: bus_rdata <= alm_day;
        sel_cmd: bus_rdata <= cmd_rd;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_irq_chk.sv
module tod_irq_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              tick_h99,
  input logic [7:0]        cur_sec,
  input logic              tod_hit,
  input logic              tod_flag,
  input logic              wd_flag,
  input logic              wd_evt,
  input logic              wd_clr,
  input logic              tod_mask,
  input logic              wd_mask,
  input logic              int_a_oe,
  input logic              int_b_oe
);
  logic alm_addr;
  assign alm_addr = (bus_addr == ADDR_W'(3)) || (bus_addr == ADDR_W'(5)) ||
                    (bus_addr == ADDR_W'(7));

  // R1
  day_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && bus_addr == ADDR_W'(7)) |=> (bus_rdata[6:3] == 4'b0));

  // R6
  tod_set_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tod_flag) |-> $past(tick_h99 && cur_sec == 8'h59));

  // R7
  tod_clear_on_access_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && alm_addr && !tod_hit) |=> !tod_flag);

  // R8
  wd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wd_clr && !wd_evt) |=> !wd_flag);

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(tod_mask && wd_mask) |-> (!int_a_oe && !int_b_oe));
endmodule

bind tod_irq_ctrl tod_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .tick_h99(tick_h99), .cur_sec(cur_sec), .tod_hit(tod_hit),
  .tod_flag(tod_flag), .wd_flag(wd_flag), .wd_evt(wd_evt), .wd_clr(wd_clr),
  .tod_mask(cfg_q.tod_mask), .wd_mask(cfg_q.wd_mask),
  .int_a_oe(int_a_oe), .int_b_oe(int_b_oe)
);

// File: tb/sim_tod_irq_ctrl.sv
`timescale 1ns/1ps
module sim_tod_irq_ctrl;
  localparam int AW = 4;
  localparam int PT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic tick_h99 = 0;
  logic [7:0] cur_sec = '0;
  logic [6:0] nxt_min = '0, nxt_hr = '0;
  logic [2:0] nxt_day = '0;
  logic wd_evt = 0, wd_clr = 0, ms_tick = 0;
  logic int_a_oe, int_b_oe;

  always #2 clk = ~clk;

  tod_irq_ctrl #(.ADDR_W(AW), .PULSE_TICKS(PT)) u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_h99(tick_h99),
    .cur_sec(cur_sec), .nxt_min(nxt_min), .nxt_hr(nxt_hr), .nxt_day(nxt_day),
    .wd_evt(wd_evt), .wd_clr(wd_clr), .ms_tick(ms_tick),
    .int_a_oe(int_a_oe), .int_b_oe(int_b_oe));

  int checks = 0, fails = 0;

  // behavioural reference
  logic [7:0] m_min, m_hr, m_day, m_rd;
  logic m_swap, m_pulse, m_wdm, m_todm, m_a, m_b;
  logic m_f [2];
  int   m_c [2];

  always @(posedge clk) begin
    logic [7:0] rd;
    logic hit, tacc;
    logic st [2];
    logic cl [2];
    if (rst) begin
      m_min = 0; m_hr = 0; m_day = 0; m_rd = 0;
      m_swap = 0; m_pulse = 0; m_wdm = 0; m_todm = 0; m_a = 0; m_b = 0;
      m_f[0] = 0; m_f[1] = 0; m_c[0] = 0; m_c[1] = 0;
    end else begin
      rd = m_rd;
      if (bus_en && !bus_we) begin
        case (int'(bus_addr))
          3: rd = m_min;
          5: rd = m_hr;
          7: rd = m_day;
          11: rd = {1'b0, m_swap, 1'b0, m_pulse, m_wdm, m_todm, m_f[1], m_f[0]};
          default: rd = 0;
        endcase
      end
      m_a = m_swap ? (m_f[0] && !m_todm) : (m_f[1] && !m_wdm);
      m_b = m_swap ? (m_f[1] && !m_wdm) : (m_f[0] && !m_todm);
      hit = tick_h99 && cur_sec == 8'h59 &&
            (m_min[7] || m_min[6:0] == nxt_min) &&
            (m_hr[7]  || m_hr[6:0]  == nxt_hr) &&
            (m_day[7] || m_day[2:0] == nxt_day);
      tacc = bus_en && (bus_addr == 3 || bus_addr == 5 || bus_addr == 7);
      st[0] = hit; cl[0] = tacc; st[1] = wd_evt; cl[1] = wd_clr;
      for (int i = 0; i < 2; i++) begin
        if (st[i]) begin m_f[i] = 1; m_c[i] = 0; end
        else if (cl[i]) m_f[i] = 0;
        else if (m_pulse && m_f[i] && ms_tick) begin
          if (m_c[i] == PT) m_f[i] = 0; else m_c[i] = m_c[i] + 1;
        end
      end
      if (bus_en && bus_we) begin
        case (int'(bus_addr))
          3: m_min = bus_wdata;
          5: m_hr = bus_wdata;
          7: m_day = {bus_wdata[7], 4'b0, bus_wdata[2:0]};
          11: begin
            m_swap = bus_wdata[6]; m_pulse = bus_wdata[4];
            m_wdm = bus_wdata[3]; m_todm = bus_wdata[2];
          end
          default: ;
        endcase
      end
      m_rd = rd;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(bus_rdata === m_rd, "R1 model read data", bus_rdata, m_rd);
    chk(int_a_oe === m_a, "R10 model pin A", int_a_oe, m_a);
    chk(int_b_oe === m_b, "R10 model pin B", int_b_oe, m_b);
    bus_en = 0; bus_we = 0; tick_h99 = 0; wd_evt = 0; wd_clr = 0; ms_tick = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    bus_en = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d; step();
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    bus_en = 1; bus_we = 0; bus_addr = AW'(a); step(); d = bus_rdata;
  endtask

  task automatic evt(input logic [7:0] s, input logic [6:0] mi, input logic [6:0] h,
                     input logic [2:0] dy);
    tick_h99 = 1; cur_sec = s; nxt_min = mi; nxt_hr = h; nxt_day = dy; step();
  endtask

  task automatic expect_cmd(input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(11, v);
    chk(v === e, req, v, e);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(int_a_oe === 0 && int_b_oe === 0, "R13 pins idle", {int_a_oe, int_b_oe}, 0);
    rd(3, v);  chk(v === 8'h00, "R13 minute alarm reset", v, 0);
    expect_cmd(8'h00, "R13 command reset");

    wr(7, 8'hFF); rd(7, v); chk(v === 8'h87, "R1 day pad bits", v, 8'h87);
    wr(7, 8'h03); wr(5, 8'h52); wr(3, 8'h30);
    rd(5, v); chk(v === 8'h52, "R1 hour readback", v, 8'h52);
    rd(3, v); chk(v === 8'h30, "R1 minute readback", v, 8'h30);
    wr(11, 8'hFF); expect_cmd(8'h5C, "R9 write only config bits");
    wr(11, 8'h40); expect_cmd(8'h40, "R9 swap level");

    evt(8'h59, 7'h30, 7'h52, 3'd3); expect_cmd(8'h41, "R2 full match");
    chk(int_a_oe === 1 && int_b_oe === 0, "R10 swap=1 tod on A", {int_a_oe, int_b_oe}, 2);
    rd(3, v); expect_cmd(8'h40, "R7 read clears flag");
    evt(8'h59, 7'h30, 7'h52, 3'd4); expect_cmd(8'h40, "R2 day mismatch");
    evt(8'h58, 7'h30, 7'h52, 3'd3); expect_cmd(8'h40, "R6 no strobe at sec 58");

    wr(7, 8'h83);
    evt(8'h59, 7'h30, 7'h52, 3'd5); expect_cmd(8'h41, "R3 day ignored");
    wr(3, 8'h30);
    evt(8'h59, 7'h30, 7'h12, 3'd5); expect_cmd(8'h40, "R3 hour still compared");

    wr(5, 8'h92);
    evt(8'h59, 7'h30, 7'h01, 3'd6); expect_cmd(8'h41, "R4 minute only");
    rd(5, v);
    evt(8'h59, 7'h31, 7'h01, 3'd6); expect_cmd(8'h40, "R4 minute mismatch");

    wr(3, 8'hB0);
    evt(8'h59, 7'h07, 7'h22, 3'd1); expect_cmd(8'h41, "R5 every minute");
    wr(11, 8'h43); expect_cmd(8'h41, "R9 flags read-only");

    rd(3, v);
    bus_en = 1; bus_we = 0; bus_addr = AW'(3);
    tick_h99 = 1; cur_sec = 8'h59; step();
    expect_cmd(8'h41, "R7 hit beats clearing access");
    rd(3, v);

    wr(11, 8'h00);
    wd_evt = 1; step(); expect_cmd(8'h02, "R8 watchdog sets");
    chk(int_a_oe === 1 && int_b_oe === 0, "R10 swap=0 watchdog on A", {int_a_oe, int_b_oe}, 2);
    wd_clr = 1; step(); expect_cmd(8'h00, "R8 watchdog clears");

    wr(11, 8'h0C);
    wd_evt = 1; step();
    evt(8'h59, 7'h00, 7'h00, 3'd0); step();
    expect_cmd(8'h0F, "R11 flags visible under mask");
    chk(int_a_oe === 0 && int_b_oe === 0, "R11 pins quiet", {int_a_oe, int_b_oe}, 0);
    rd(3, v); wd_clr = 1; step();

    wr(11, 8'h50);
    evt(8'h59, 7'h11, 7'h11, 3'd2); step();
    for (int i = 0; i < PT; i++) begin ms_tick = 1; step(); step(); end
    expect_cmd(8'h51, "R12 held through PULSE_TICKS ticks");
    chk(int_a_oe === 1, "R12 pin active in pulse", int_a_oe, 1);
    ms_tick = 1; step();
    expect_cmd(8'h50, "R12 released on extra tick");
    chk(int_a_oe === 0, "R12 pin released", int_a_oe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule